// File: doc/BRIEF.md
# Read-Address Sequence Write-Protect Guard

This block watches the read traffic of a byte-wide memory port and keeps a single write-protect flag. The flag comes out of reset set, and program and erase commands elsewhere in the chip are only accepted while it is clear. Software changes the flag without writing any data. It issues seven back-to-back reads at a fixed list of addresses. Only the read address matters; the data bus plays no part. The first six addresses are common to both keys, and the seventh address selects whether the flag is cleared or set.

The design is synchronous. Each completed read is presented as a one-cycle `rd_strobe` pulse carrying the address that was latched at the end of that read. Each completed write is presented as a one-cycle `wr_strobe` pulse. Progress through the key is held in a state machine with seven named states:

- `SEQ_IDLE` means no key address has been seen yet.
- `SEQ_S1` to `SEQ_S6` mean that one to six key addresses have been matched in order.

The transitions are:

- **advance**: a read hits the next key address, and the machine moves one state on.
- **restart**: a read misses but hits the first key address, and the machine moves to `SEQ_S1`.
- **drop**: any other missing read returns the machine to `SEQ_IDLE`.
- **abort**: a write strobe returns the machine to `SEQ_IDLE`.
- **finish**: the seventh read is taken from `SEQ_S6` back to `SEQ_IDLE`, updating the flag and pulsing an event output.

Top module: `rdseq_guard`

## Requirements
- R1: While reset is held, and in the first cycle after it, `protected_o` is 1 and both event pulses are 0.
- R2: Reads at hex addresses 1823, 1820, 1822, 0418, 041B, 0419, 041A, in that order, clear `protected_o`. They also raise `unlock_pulse`. Both changes appear in the cycle after the seventh read strobe.
- R3: The same first six reads followed by a read at 040A set `protected_o` and raise `lock_pulse` in the cycle after the seventh strobe.
- R4: Only address bits 12 down to 0 are compared. Any value on bits 18 down to 13 gives the same result.
- R5: A read that does not match the next expected key address returns the match to the start. If that read's address equals 1823, it counts as the first key step.
- R6: A write strobe aborts any partial sequence. When a read and a write strobe arrive in the same cycle, the write wins.
- R7: Cycles without a read strobe neither advance nor reset the progress through a key.
- R8: `unlock_pulse` and `lock_pulse` are each one cycle wide and never high together. `protected_o` changes only in a cycle in which one of them is high.
- R9: Write strobes never change `protected_o`, whatever their address. A seventh-step address read without the first six before it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | One-cycle pulse per completed read |
| wr_strobe | input | 1 | One-cycle pulse per completed write |
| rd_addr | input | 19 | Address latched at the end of the read |
| protected_o | output | 1 | Write-protect flag, 1 = program/erase blocked |
| unlock_pulse | output | 1 | One-cycle pulse when an unprotect key completes |
| lock_pulse | output | 1 | One-cycle pulse when a protect key completes |

## Verification
A wrong sequence state is invisible until the seventh read. At that point it shows up in one of three ways: a missing event pulse, an unexpected event pulse, or a flag that does not move. The bench therefore compares the flag and both pulses against a behavioural model on every clock. It drives the traffic that tests how progress is kept or lost: idle gaps, near-miss addresses, restarts on the first key address, write aborts and high address bits. A faulty step counter then fails within one cycle of the first affected sequence completing.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    localparam int KEY_W   = 13;
    localparam int KEY_LEN = 7;
    localparam int STEP_W  = $clog2(KEY_LEN);

    localparam logic [KEY_W-1:0] TAIL_UNLOCK = 13'h041A;
    localparam logic [KEY_W-1:0] TAIL_LOCK   = 13'h040A;

    typedef enum logic [STEP_W-1:0] {
        SEQ_IDLE = 3'd0,
        SEQ_S1   = 3'd1,
        SEQ_S2   = 3'd2,
        SEQ_S3   = 3'd3,
        SEQ_S4   = 3'd4,
        SEQ_S5   = 3'd5,
        SEQ_S6   = 3'd6
    } seq_state_e;

    // Shared prefix of both keys, step 0 .. step 5
    function automatic logic [KEY_W-1:0] key_at(input int idx);
        logic [KEY_W-1:0] v;
        case (idx)
            0:       v = 13'h1823;
            1:       v = 13'h1820;
            2:       v = 13'h1822;
            3:       v = 13'h0418;
            4:       v = 13'h041B;
            default: v = 13'h0419;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rsg_step_match.sv
module rsg_step_match
    import rsg_pkg::*;
(
    input  logic [KEY_W-1:0]  addr_low,
    input  seq_state_e        state,
    output logic              hit_step,
    output logic              hit_first,
    output logic              hit_unlock,
    output logic              hit_lock
);
    localparam int PREFIX_LEN = KEY_LEN - 1;

    logic [PREFIX_LEN-1:0] prefix_hit;

    genvar gi;
    generate
        for (gi = 0; gi < PREFIX_LEN; gi++) begin : g_cmp
            assign prefix_hit[gi] = (addr_low == key_at(gi));
        end
    endgenerate

    always_comb begin
        hit_step = 1'b0;
        if (int'(state) < PREFIX_LEN)
            hit_step = prefix_hit[state];
    end

    assign hit_first  = prefix_hit[0];
    assign hit_unlock = (addr_low == TAIL_UNLOCK);
    assign hit_lock   = (addr_low == TAIL_LOCK);

endmodule

// File: rtl/rsg_seq_fsm.sv
module rsg_seq_fsm
    import rsg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_strobe,
    input  logic        wr_strobe,
    input  logic        hit_step,
    input  logic        hit_first,
    input  logic        hit_unlock,
    input  logic        hit_lock,
    output seq_state_e  state,
    output logic        protected_o,
    output logic        unlock_pulse,
    output logic        lock_pulse
);
    seq_state_e state_nx;
    logic       rd_take;
    logic       fin_unlock;
    logic       fin_lock;

    assign rd_take    = rd_strobe && !wr_strobe;
    assign fin_unlock = rd_take && (state == SEQ_S6) && hit_unlock;
    assign fin_lock   = rd_take && (state == SEQ_S6) && hit_lock;

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (wr_strobe) begin
            state_nx = SEQ_IDLE;                        // abort
        end else if (rd_strobe) begin
            unique case (state)
                SEQ_S6: begin                           // finish or drop/restart
                    state_nx = hit_first ? SEQ_S1 : SEQ_IDLE;
                end
                SEQ_IDLE, SEQ_S1, SEQ_S2, SEQ_S3, SEQ_S4, SEQ_S5: begin
                    if (hit_step)
                        state_nx = seq_state_e'(state + 3'd1);   // advance
                    else if (hit_first)
                        state_nx = SEQ_S1;                      // restart
                    else
                        state_nx = SEQ_IDLE;                    // drop
                end
                default: state_nx = SEQ_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEQ_IDLE;
        else
            state <= state_nx;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            protected_o  <= 1'b1;
            unlock_pulse <= 1'b0;
            lock_pulse   <= 1'b0;
        end else begin
            unlock_pulse <= fin_unlock;
            lock_pulse   <= fin_lock;
            if (fin_unlock)
                protected_o <= 1'b0;
            else if (fin_lock)
                protected_o <= 1'b1;
        end
    end

endmodule

// File: rtl/rdseq_guard.sv
module rdseq_guard
    import rsg_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              protected_o,
    output logic              unlock_pulse,
    output logic              lock_pulse
);
    seq_state_e state;
    logic       hit_step;
    logic       hit_first;
    logic       hit_unlock;
    logic       hit_lock;

    rsg_step_match u_match (
        .addr_low   (rd_addr[KEY_W-1:0]),
        .state      (state),
        .hit_step   (hit_step),
        .hit_first  (hit_first),
        .hit_unlock (hit_unlock),
        .hit_lock   (hit_lock)
    );

    rsg_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_strobe    (rd_strobe),
        .wr_strobe    (wr_strobe),
        .hit_step     (hit_step),
        .hit_first    (hit_first),
        .hit_unlock   (hit_unlock),
        .hit_lock     (hit_lock),
        .state        (state),
        .protected_o  (protected_o),
        .unlock_pulse (unlock_pulse),
        .lock_pulse   (lock_pulse)
    );

endmodule

// File: rtl/rsg_checker.sv
module rsg_checker (
    input logic clk,
    input logic rst_n,
    input logic rd_strobe,
    input logic wr_strobe,
    input logic protected_o,
    input logic unlock_pulse,
    input logic lock_pulse
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlock_pulse && lock_pulse)); // R8

    AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_pulse |-> !protected_o); // R2

    AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_pulse |-> protected_o); // R3

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_pulse || lock_pulse) |=> !(unlock_pulse || lock_pulse)); // R8

    AST_PROT_ONLY_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(protected_o) |-> (unlock_pulse || lock_pulse)); // R8

    AST_NO_READ_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe || wr_strobe) |=> !(unlock_pulse || lock_pulse)); // R6

endmodule

bind rdseq_guard rsg_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_strobe    (rd_strobe),
    .wr_strobe    (wr_strobe),
    .protected_o  (protected_o),
    .unlock_pulse (unlock_pulse),
    .lock_pulse   (lock_pulse)
);

// File: tb/rdseq_guard_bench.sv
`timescale 1ns/1ps
module rdseq_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_strobe = 1'b0;
    logic        wr_strobe = 1'b0;
    logic [18:0] rd_addr = '0;
    logic        protected_o, unlock_pulse, lock_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;   // 125 MHz

    rdseq_guard u_rdseq_guard (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .rd_addr(rd_addr), .protected_o(protected_o),
        .unlock_pulse(unlock_pulse), .lock_pulse(lock_pulse)
    );

    // Behavioural reference model
    int          keys[$] = '{'h1823, 'h1820, 'h1822, 'h0418, 'h041B, 'h0419};
    int          m_step  = 0;
    logic        m_prot  = 1'b1;
    logic        m_unl   = 1'b0;
    logic        m_lck   = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0; m_prot = 1'b1; m_unl = 1'b0; m_lck = 1'b0;
        end else begin
            int a;
            a = int'(rd_addr[12:0]);
            m_unl = 1'b0; m_lck = 1'b0;
            if (wr_strobe) begin
                m_step = 0;
            end else if (rd_strobe) begin
                if (m_step == 6 && a == 'h041A) begin
                    m_unl = 1'b1; m_prot = 1'b0; m_step = 0;
                end else if (m_step == 6 && a == 'h040A) begin
                    m_lck = 1'b1; m_prot = 1'b1; m_step = 0;
                end else if (m_step < 6 && a == keys[m_step]) begin
                    m_step = m_step + 1;
                end else if (a == keys[0]) begin
                    m_step = 1;
                end else begin
                    m_step = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle model comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(protected_o === m_prot, "R8 model protected_o", protected_o, m_prot);
            check(unlock_pulse === m_unl, "R2 model unlock_pulse", unlock_pulse, m_unl);
            check(lock_pulse === m_lck, "R3 model lock_pulse", lock_pulse, m_lck);
        end
    end

    task automatic do_read(input logic [18:0] a);
        @(negedge clk); rd_strobe = 1'b1; rd_addr = a;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic do_write(input logic [18:0] a);
        @(negedge clk); wr_strobe = 1'b1; rd_addr = a;
        @(negedge clk); wr_strobe = 1'b0;
    endtask

    task automatic prefix(input logic [18:0] hi);
        for (int i = 0; i < 6; i++) do_read(hi | 19'(keys[i]));
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(protected_o === 1'b1, "R1 in reset protected", protected_o, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(protected_o === 1'b1 && !unlock_pulse && !lock_pulse,
              "R1 after reset", {protected_o, unlock_pulse, lock_pulse}, 3'b100);

        // R9: lone tail read, writes with reset-command-like data
        do_read(19'h041A);
        check(protected_o === 1'b1, "R9 lone tail read", protected_o, 1);
        do_write(19'h0000);
        check(protected_o === 1'b1, "R9 write no effect", protected_o, 1);

        // R2: unlock
        prefix(19'h0);
        do_read(19'h041A);
        check(unlock_pulse === 1'b1 && protected_o === 1'b0, "R2 unlock",
              {unlock_pulse, protected_o}, 2'b10);
        @(negedge clk);
        check(unlock_pulse === 1'b0, "R8 pulse width", unlock_pulse, 0);

        // R4 + R3: lock with high address bits set
        prefix(19'h7E000);
        do_read(19'h5640A);
        check(lock_pulse === 1'b1 && protected_o === 1'b1, "R3 R4 lock high bits",
              {lock_pulse, protected_o}, 2'b11);

        // R5: mismatch mid-sequence kills it
        do_read(19'h1823); do_read(19'h1820); do_read(19'h0000);
        do_read(19'h1822); do_read(19'h0418); do_read(19'h041B); do_read(19'h0419);
        do_read(19'h041A);
        check(protected_o === 1'b1, "R5 mismatch drop", protected_o, 1);

        // R5: restart on first key address
        do_read(19'h1823); do_read(19'h1820); do_read(19'h1823);
        for (int i = 1; i < 6; i++) do_read(19'(keys[i]));
        do_read(19'h041A);
        check(protected_o === 1'b0, "R5 restart counts step 1", protected_o, 0);

        // R6: write mid-sequence aborts
        prefix(19'h0);
        do_write(19'h0FF);
        do_read(19'h040A);
        check(protected_o === 1'b0 && !lock_pulse, "R6 write abort", protected_o, 0);

        // R6: read and write together at the seventh step
        prefix(19'h0);
        @(negedge clk); rd_strobe = 1'b1; wr_strobe = 1'b1; rd_addr = 19'h040A;
        @(negedge clk); rd_strobe = 1'b0; wr_strobe = 1'b0;
        check(protected_o === 1'b0 && !lock_pulse, "R6 write wins", protected_o, 0);

        // R7: idle gaps keep progress
        for (int i = 0; i < 6; i++) begin
            do_read(19'(keys[i]));
            repeat (i + 2) @(negedge clk);
        end
        do_read(19'h040A);
        check(protected_o === 1'b1 && lock_pulse === 1'b1, "R7 gaps kept",
              {protected_o, lock_pulse}, 2'b11);

        // Random traffic biased toward key addresses
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [18:0] a;
            r = int'($urandom_range(0, 9));
            if (r < 6) a = 19'(keys[r]);
            else if (r == 6) a = 19'h041A;
            else if (r == 7) a = 19'h040A;
            else a = 19'($urandom);
            a[18:13] = 6'($urandom);
            @(negedge clk);
            rd_addr   = a;
            rd_strobe = ($urandom_range(0, 3) != 0);
            wr_strobe = ($urandom_range(0, 30) == 0);
        end
        @(negedge clk); rd_strobe = 1'b0; wr_strobe = 1'b0;
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule